// File: doc/BRIEF.md
# Hot-Swap Fault Supervisor

This block supervises a high-side hot-swap pass switch. Each clock it registers a sampled load-current word, a load-voltage word and the enable input. It multiplies current by voltage to get load power and runs three protection paths on the registered values. The overpower path and the overcurrent path each build up a count of consecutive cycles in which their condition holds. The length of each delay is programmable, and a minimum length is enforced for each. The short-circuit path trips after a fixed two-cycle confirmation.

On a trip the block latches an active-low fault flag and removes the gate-enable command. Two cause flags show which delay path tripped. The latch is cleared only when enable is taken low, and gate drive returns only once enable is high again. A current-only mode switches the power path off.

Current words carry 3 fractional bits (LSB 0.125 A). Voltage words carry 4 fractional bits (LSB 0.0625 V). Power therefore has an LSB of 1/128 W.

Top module: `hotswap_fault_sup`

## Requirements
- R1: Overpower holds when the product of registered current and voltage is strictly greater than 230 W, which is 29440 in power LSBs. An exactly equal product is not overpower.
- R2: Overcurrent holds when registered current is strictly greater than 40 A (code 320). Short circuit holds when current is strictly greater than a fixed 130 A (code 1040).
- R3: A path trips when its condition has held for its target number of consecutive cycles. If the condition is false for any one cycle, the accumulator goes back to zero. If an input is applied at the edge that registers it, fault_n falls exactly target edges later.
- R4: The overpower target is the larger of op_delay and 10. The overcurrent target is the larger of oc_delay and 8.
- R5: Short circuit trips after 2 cycles, whatever values the programmed delays hold.
- R6: A trip sets fault_n low and drives gate_en low. Both stay that way while enable stays high, even after every condition has cleared.
- R7: While enable is low, gate_en is low. The fault latch, both cause flags and both accumulators clear on the second edge after enable is seen low. gate_en returns high one edge after enable is seen high again.
- R8: The cause flags are {op_cause, oc_cause}. A trip by overpower gives 10, by overcurrent 01, and by short circuit 00. Both flags are 0 while no fault is latched.
- R9: If several paths trip in the same cycle, the latch is set once. The priority is short circuit first, then overcurrent, then overpower.
- R10: With current_only high, the overpower path never counts and never trips. The current-based paths are not affected.
- R11: During and straight after reset, gate_en is 0, fault_n is 1 and both cause flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the latch |
| enable | input | 1 | Active-high enable; taking it low clears the fault |
| load_cur | input | 11 | Load current, unsigned, LSB 0.125 A |
| load_volt | input | 9 | Load voltage, unsigned, LSB 0.0625 V |
| op_delay | input | 16 | Overpower delay in cycles |
| oc_delay | input | 16 | Overcurrent delay in cycles |
| current_only | input | 1 | High disables the overpower path |
| gate_en | output | 1 | Gate drive command |
| fault_n | output | 1 | Latched fault, active low |
| op_cause | output | 1 | Overpower delay path caused the trip |
| oc_cause | output | 1 | Overcurrent delay path caused the trip |

## Verification
Some rules are checked by the assertions on every cycle. Gate drive falls one cycle after enable is seen low, and the latched fault persists while enable stays high. The cause flags are never both high, and they appear only while a fault is latched. A short circuit held for two cycles removes gate drive. The exact trip cycle of each delay path, the enforced minimum delays, the strict threshold boundaries, the accumulator restart, the priority between paths that trip together and current-only mode cannot be seen cycle by cycle. Only the scenarios in the bench show these, through their expected output values.

// File: rtl/hotswap_fault_sup.sv
module hotswap_fault_sup #(
  parameter int I_W        = 11,
  parameter int V_W        = 9,
  parameter int I_FRAC     = 3,
  parameter int V_FRAC     = 4,
  parameter int DLY_W      = 16,
  parameter int OC_AMPS    = 40,
  parameter int PWR_WATTS  = 230,
  parameter int OP_MIN_CYC = 10,
  parameter int OC_MIN_CYC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [I_W-1:0]   load_cur,
  input  logic [V_W-1:0]   load_volt,
  input  logic [DLY_W-1:0] op_delay,
  input  logic [DLY_W-1:0] oc_delay,
  input  logic             current_only,
  output logic             gate_en,
  output logic             fault_n,
  output logic             op_cause,
  output logic             oc_cause
);
  localparam int P_W     = I_W + V_W;
  localparam int SC_AMPS = 130;
  localparam int SC_CYC  = 2;
  localparam logic [P_W-1:0] PWR_LIM = P_W'(PWR_WATTS) << (I_FRAC + V_FRAC);
  localparam logic [I_W-1:0] OC_LIM  = I_W'(OC_AMPS) << I_FRAC;
  localparam logic [I_W-1:0] SC_LIM  = I_W'(SC_AMPS) << I_FRAC;

  logic             en_q, off_q;
  logic [I_W-1:0]   cur_q;
  logic [V_W-1:0]   volt_q;
  logic [P_W-1:0]   power;
  logic             op_cond, oc_cond, sc_cond;
  logic [DLY_W-1:0] op_cnt, oc_cnt, op_tgt, oc_tgt;
  logic [1:0]       sc_cnt;
  logic             op_hit, oc_hit, sc_hit;
  logic             fault_q, op_q, oc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      off_q  <= 1'b0;
      cur_q  <= '0;
      volt_q <= '0;
    end else begin
      en_q   <= enable;
      off_q  <= current_only;
      cur_q  <= load_cur;
      volt_q <= load_volt;
    end
  end

  assign power   = P_W'(cur_q) * P_W'(volt_q);
  assign op_cond = !off_q && (power > PWR_LIM);
  assign oc_cond = cur_q > OC_LIM;
  assign sc_cond = cur_q > SC_LIM;

  assign op_tgt = (op_delay < DLY_W'(OP_MIN_CYC)) ? DLY_W'(OP_MIN_CYC) : op_delay;
  assign oc_tgt = (oc_delay < DLY_W'(OC_MIN_CYC)) ? DLY_W'(OC_MIN_CYC) : oc_delay;

  assign op_hit = op_cond && (op_cnt >= op_tgt - DLY_W'(1));
  assign oc_hit = oc_cond && (oc_cnt >= oc_tgt - DLY_W'(1));
  assign sc_hit = sc_cond && (sc_cnt >= 2'(SC_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_cnt <= '0;
      oc_cnt <= '0;
      sc_cnt <= '0;
    end else if (!en_q) begin
      op_cnt <= '0;
      oc_cnt <= '0;
      sc_cnt <= '0;
    end else if (!fault_q) begin
      op_cnt <= op_cond ? op_cnt + DLY_W'(1) : '0;
      oc_cnt <= oc_cond ? oc_cnt + DLY_W'(1) : '0;
      sc_cnt <= sc_cond ? sc_cnt + 2'd1 : 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      op_q    <= 1'b0;
      oc_q    <= 1'b0;
    end else if (!en_q) begin
      fault_q <= 1'b0;
      op_q    <= 1'b0;
      oc_q    <= 1'b0;
    end else if (!fault_q && (op_hit || oc_hit || sc_hit)) begin
      fault_q <= 1'b1;
      op_q    <= !sc_hit && !oc_hit;
      oc_q    <= !sc_hit && oc_hit;
    end
  end

  assign gate_en  = en_q && !fault_q;
  assign fault_n  = !fault_q;
  assign op_cause = op_q;
  assign oc_cause = oc_q;

  AST_GATE_OFF_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !gate_en); // R7
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !fault_n) |=> !fault_n); // R6
  AST_CAUSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_cause, oc_cause})); // R8
  AST_CAUSE_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_cause || oc_cause) |-> !fault_n); // R8
  AST_SC_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q) && sc_cond && $past(sc_cond)) |=> !gate_en); // R5
endmodule

// File: tb/sim_hotswap_fault_sup.sv
module sim_hotswap_fault_sup;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, enable = 1'b0, current_only = 1'b0;
  logic [10:0] load_cur = '0;
  logic [8:0]  load_volt = '0;
  logic [15:0] op_delay = '0, oc_delay = '0;
  logic        gate_en, fault_n, op_cause, oc_cause;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hotswap_fault_sup u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load_cur(load_cur),
    .load_volt(load_volt), .op_delay(op_delay), .oc_delay(oc_delay),
    .current_only(current_only), .gate_en(gate_en), .fault_n(fault_n),
    .op_cause(op_cause), .oc_cause(oc_cause));

  typedef struct packed {
    logic [10:0] cur;
    logic [8:0]  volt;
    logic [15:0] opd;
    logic [15:0] ocd;
    logic        off;
    logic [7:0]  hold;
    logic [3:0]  exp;
  } vec_t;

  // exp = {gate_en, fault_n, op_cause, oc_cause}; hold = negedges after applying
  localparam vec_t VECS [13] = '{
    '{11'd152,  9'd192, 16'd0,  16'd0,  1'b0, 8'd40, 4'b1100}, // R1 19 A x 12 V below limit
    '{11'd176,  9'd192, 16'd0,  16'd0,  1'b0, 8'd11, 4'b0010}, // R4 op min 10
    '{11'd176,  9'd192, 16'd0,  16'd0,  1'b0, 8'd10, 4'b1100}, // R3 one cycle short
    '{11'd336,  9'd192, 16'd20, 16'd12, 1'b0, 8'd13, 4'b0001}, // R2 overcurrent first
    '{11'd336,  9'd192, 16'd5,  16'd30, 1'b0, 8'd11, 4'b0010}, // R8 overpower first
    '{11'd1048, 9'd192, 16'd0,  16'd0,  1'b0, 8'd3,  4'b0000}, // R5 short circuit
    '{11'd1048, 9'd192, 16'd0,  16'd0,  1'b0, 8'd2,  4'b1100}, // R5 one cycle short
    '{11'd176,  9'd192, 16'd0,  16'd0,  1'b1, 8'd50, 4'b1100}, // R10 power ignored
    '{11'd336,  9'd192, 16'd0,  16'd0,  1'b1, 8'd9,  4'b0001}, // R10 oc still trips, R4 min 8
    '{11'd336,  9'd192, 16'd15, 16'd15, 1'b0, 8'd16, 4'b0001}, // R9 tie oc over op
    '{11'd320,  9'd64,  16'd0,  16'd0,  1'b0, 8'd30, 4'b1100}, // R2 exactly 40 A
    '{11'd160,  9'd184, 16'd0,  16'd0,  1'b0, 8'd30, 4'b1100}, // R1 exactly 230 W
    '{11'd161,  9'd184, 16'd0,  16'd0,  1'b0, 8'd11, 4'b0010}  // R1 just above
  };

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {gate_en, fault_n, op_cause, oc_cause};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {gate_en,fault_n,op,oc} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic disarm();
    enable = 1'b0; load_cur = '0; current_only = 1'b0;
    step(2);
  endtask

  initial begin
    load_volt = 9'd192;
    enable = 1'b1;
    step(3);
    chk("R11 in reset", 4'b0100);
    rst_n = 1'b1;
    enable = 1'b0;
    step(1);
    chk("R11 after reset", 4'b0100);

    foreach (VECS[i]) begin
      disarm();
      chk("R7 gate low while disabled", 4'b0100);
      enable = 1'b1;
      load_cur = VECS[i].cur; load_volt = VECS[i].volt;
      op_delay = VECS[i].opd; oc_delay = VECS[i].ocd;
      current_only = VECS[i].off;
      step(int'(VECS[i].hold));
      chk($sformatf("R3 vector %0d", i), VECS[i].exp);
    end

    // accumulator restart
    disarm();
    op_delay = 0; oc_delay = 0; load_volt = 9'd192;
    enable = 1'b1; load_cur = 11'd176;
    step(8);
    load_cur = '0;
    step(1);
    load_cur = 11'd176;
    step(10);
    chk("R3 restart no early trip", 4'b1100);
    step(1);
    chk("R3 restart trips", 4'b0010);

    // latch holds after condition clears
    load_cur = '0;
    step(5);
    chk("R6 latch holds", 4'b0010);

    // clear through enable
    enable = 1'b0;
    step(1);
    chk("R7 gate low, fault held one edge", 4'b0010);
    step(1);
    chk("R7 cleared", 4'b0100);
    enable = 1'b1;
    step(1);
    chk("R7 gate resumes", 4'b1100);
    step(20);
    chk("R6 no spurious trip", 4'b1100);

    // short circuit ignores long programmed delays
    op_delay = 16'd500; oc_delay = 16'd500;
    load_cur = 11'd1100;
    step(3);
    chk("R9 short circuit wins", 4'b0000);
    load_cur = '0;
    step(4);
    chk("R6 sc latch holds", 4'b0000);

    disarm();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule